// File: doc/BRIEF.md
# Three-Phase Instruction Sequencer

This block is the control sequencer of a small multicycle processor. It walks through three phases, one per clock: fetch, decode and execute. In fetch it reads the program memory at the program counter, latches the word into the instruction register, copies the program counter into the memory address register and advances the program counter. In decode it splits the 64-bit word into an opcode, a first operand and a second operand, and registers a set of execute strobes for the datapath.

In execute it drives the register write-back, flag-update, push and pop strobes for one cycle. It also decides whether to load the program counter. Jumps and taken branches load the first operand. A return loads the value popped from the stack. Branch conditions are tested against the sign (S) and zero (Z) bits of an internal status register, which takes the ALU flags whenever the flag-update strobe fires. An opcode outside the defined set clears every sequencer register at the end of its execute cycle. An illegal phase code does the same.

Top module: `instruction_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, instruction register, memory address register, status register, decoded fields and all strobes clear to zero, and the phase goes to fetch (`phase` 0).
- R2: At the fetch edge the instruction register takes `pmem_rdata` read at `pmem_addr`, `mar` takes the old program counter and the program counter increments by one, wrapping at `PC_W` bits.
- R3: At the decode edge `opcode` takes instruction bits 63:48, `opnd1` takes bits 47:32 and `opnd2` takes bits 31:0.
- R4: Strobes are high only during execute. LDI (0x0001) and MOV (0x0002) raise `wb_en` only. ADD (0x0003), SUB (0x0004), ADDI (0x0005) and SUBI (0x0006) raise `wb_en` and `flag_en`. NOP (0x0000) and branches raise none.
- R5: The compares CP (0x0007) and CPI (0x0008) raise `flag_en` without `wb_en`.
- R6: When `flag_en` is high at the execute edge, `status` takes `alu_flags` (bit 3 S, bit 2 N, bit 1 Z, bit 0 C). Otherwise `status` holds.
- R7: JMP (0x0010) always loads the program counter from `opnd1[PC_W-1:0]`. The conditional branches do the same only when their condition holds: BREQ (0x0011) on Z set, BRNE (0x0012) on Z clear, BRGE (0x0013) on S clear, BRGT (0x0014) on S and Z both clear, BRLE (0x0015) on S or Z set, and BRLT (0x0016) on S set. A branch that is not taken keeps the incremented counter.
- R8: CALL (0x0017) raises `push_en` with `push_data` equal to the incremented program counter and then jumps to `opnd1`. RET (0x0018) raises `pop_en` and loads the program counter from `pop_data`.
- R9: Any other opcode clears the program counter, instruction register, memory address register, status register and decoded fields at the end of its execute cycle, and the phase returns to fetch.
- R10: The phase always steps fetch (0) to decode (1) to execute (2) and back to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pmem_addr | output | PC_W | Program memory read address (program counter) |
| pmem_rdata | input | 64 | Program memory read data |
| alu_flags | input | 4 | Flags from the ALU: S, N, Z, C |
| pop_data | input | PC_W | Value at the top of the stack |
| phase | output | 2 | Current phase: 0 fetch, 1 decode, 2 execute |
| ir | output | 64 | Instruction register |
| mar | output | PC_W | Address of the instruction being executed |
| opcode | output | 16 | Decoded opcode |
| opnd1 | output | 16 | Decoded first operand |
| opnd2 | output | 32 | Decoded second operand |
| status | output | 4 | Status register |
| wb_en | output | 1 | Register write-back strobe |
| flag_en | output | 1 | Flag-update strobe |
| push_en | output | 1 | Stack push strobe |
| pop_en | output | 1 | Stack pop strobe |
| push_data | output | PC_W | Return address to push |

## Verification
The branch logic is swept over all six conditional opcodes. Each one runs against all four S/Z combinations, with the flags first set through a compare, so that every taken and not-taken outcome is seen. Each branch gets its own target, so a wrong target cannot be mistaken for a right one. Separate instructions of each strobe class show the difference between write-back-with-flags, write-back-only, flags-only and no strobe. A call/return pair checks the pushed return address and the popped reload. An undefined opcode, issued with a nonzero counter and status, shows that the clear really happens.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int INSTR_W = 64;
  localparam int OPC_W   = 16;
  localparam int OPA_W   = 16;
  localparam int OPB_W   = 32;
  localparam int FLG_W   = 4;
  localparam int FLG_Z   = 1;
  localparam int FLG_S   = 3;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2
  } phase_e;

  typedef enum logic [3:0] {
    BC_NONE, BC_ALWAYS, BC_EQ, BC_NE, BC_GE, BC_GT, BC_LE, BC_LT, BC_RET
  } bcond_e;

  typedef struct packed {
    logic   legal;
    logic   wb;
    logic   flag;
    logic   push;
    logic   pop;
    bcond_e cond;
  } ctrl_t;

  localparam logic [OPC_W-1:0] OPC_NOP  = 16'h0000;
  localparam logic [OPC_W-1:0] OPC_LDI  = 16'h0001;
  localparam logic [OPC_W-1:0] OPC_MOV  = 16'h0002;
  localparam logic [OPC_W-1:0] OPC_ADD  = 16'h0003;
  localparam logic [OPC_W-1:0] OPC_SUB  = 16'h0004;
  localparam logic [OPC_W-1:0] OPC_ADDI = 16'h0005;
  localparam logic [OPC_W-1:0] OPC_SUBI = 16'h0006;
  localparam logic [OPC_W-1:0] OPC_CP   = 16'h0007;
  localparam logic [OPC_W-1:0] OPC_CPI  = 16'h0008;
  localparam logic [OPC_W-1:0] OPC_JMP  = 16'h0010;
  localparam logic [OPC_W-1:0] OPC_BREQ = 16'h0011;
  localparam logic [OPC_W-1:0] OPC_BRNE = 16'h0012;
  localparam logic [OPC_W-1:0] OPC_BRGE = 16'h0013;
  localparam logic [OPC_W-1:0] OPC_BRGT = 16'h0014;
  localparam logic [OPC_W-1:0] OPC_BRLE = 16'h0015;
  localparam logic [OPC_W-1:0] OPC_BRLT = 16'h0016;
  localparam logic [OPC_W-1:0] OPC_CALL = 16'h0017;
  localparam logic [OPC_W-1:0] OPC_RET  = 16'h0018;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl = '{legal: 1'b1, wb: 1'b0, flag: 1'b0, push: 1'b0, pop: 1'b0, cond: BC_NONE};
    case (opc)
      OPC_NOP: ;
      OPC_LDI, OPC_MOV: ctrl.wb = 1'b1;
      OPC_ADD, OPC_SUB, OPC_ADDI, OPC_SUBI: begin
        ctrl.wb   = 1'b1;
        ctrl.flag = 1'b1;
      end
      OPC_CP, OPC_CPI: ctrl.flag = 1'b1;
      OPC_JMP:  ctrl.cond = BC_ALWAYS;
      OPC_BREQ: ctrl.cond = BC_EQ;
      OPC_BRNE: ctrl.cond = BC_NE;
      OPC_BRGE: ctrl.cond = BC_GE;
      OPC_BRGT: ctrl.cond = BC_GT;
      OPC_BRLE: ctrl.cond = BC_LE;
      OPC_BRLT: ctrl.cond = BC_LT;
      OPC_CALL: begin
        ctrl.push = 1'b1;
        ctrl.cond = BC_ALWAYS;
      end
      OPC_RET: begin
        ctrl.pop  = 1'b1;
        ctrl.cond = BC_RET;
      end
      default: ctrl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_branch.sv
module seq_branch
  import seq_pkg::*;
(
  input  bcond_e cond,
  input  logic   flag_s,
  input  logic   flag_z,
  output logic   redirect,
  output logic   from_stack
);
  always_comb begin
    from_stack = 1'b0;
    case (cond)
      BC_ALWAYS: redirect = 1'b1;
      BC_EQ:     redirect = flag_z;
      BC_NE:     redirect = !flag_z;
      BC_GE:     redirect = !flag_s;
      BC_GT:     redirect = !flag_s && !flag_z;
      BC_LE:     redirect = flag_s || flag_z;
      BC_LT:     redirect = flag_s;
      BC_RET: begin
        redirect   = 1'b1;
        from_stack = 1'b1;
      end
      default:   redirect = 1'b0;
    endcase
  end
endmodule

// File: rtl/instruction_sequencer.sv
module instruction_sequencer
  import seq_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [PC_W-1:0]      pmem_addr,
  input  logic [INSTR_W-1:0]   pmem_rdata,
  input  logic [FLG_W-1:0]     alu_flags,
  input  logic [PC_W-1:0]      pop_data,
  output logic [1:0]           phase,
  output logic [INSTR_W-1:0]   ir,
  output logic [PC_W-1:0]      mar,
  output logic [OPC_W-1:0]     opcode,
  output logic [OPA_W-1:0]     opnd1,
  output logic [OPB_W-1:0]     opnd2,
  output logic [FLG_W-1:0]     status,
  output logic                 wb_en,
  output logic                 flag_en,
  output logic                 push_en,
  output logic                 pop_en,
  output logic [PC_W-1:0]      push_data
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  phase_e               state;
  logic [PC_W-1:0]      pc_q, mar_q;
  logic [INSTR_W-1:0]   ir_q;
  logic [OPC_W-1:0]     opc_q;
  logic [OPA_W-1:0]     opa_q;
  logic [OPB_W-1:0]     opb_q;
  logic [FLG_W-1:0]     sr_q;
  ctrl_t                ctrl_q, dec_ctrl;
  logic                 redirect, from_stack, wipe;

  seq_decode u_dec (
    .opc  (ir_q[INSTR_W-1 -: OPC_W]),
    .ctrl (dec_ctrl)
  );

  seq_branch u_br (
    .cond       (ctrl_q.cond),
    .flag_s     (sr_q[FLG_S]),
    .flag_z     (sr_q[FLG_Z]),
    .redirect   (redirect),
    .from_stack (from_stack)
  );

  always_comb begin
    case (state)
      PH_FETCH, PH_DECODE: wipe = 1'b0;
      PH_EXEC:             wipe = !ctrl_q.legal;
      default:             wipe = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      state  <= PH_FETCH;
      pc_q   <= '0;
      mar_q  <= '0;
      ir_q   <= '0;
      opc_q  <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      sr_q   <= '0;
      ctrl_q <= '0;
    end else begin
      case (state)
        PH_FETCH: begin
          ir_q  <= pmem_rdata;
          mar_q <= pc_q;
          pc_q  <= pc_q + PC_ONE;
          state <= PH_DECODE;
        end
        PH_DECODE: begin
          opc_q  <= ir_q[INSTR_W-1 -: OPC_W];
          opa_q  <= ir_q[OPB_W +: OPA_W];
          opb_q  <= ir_q[OPB_W-1:0];
          ctrl_q <= dec_ctrl;
          state  <= PH_EXEC;
        end
        default: begin
          if (redirect) pc_q <= from_stack ? pop_data : opa_q[PC_W-1:0];
          if (ctrl_q.flag) sr_q <= alu_flags;
          ctrl_q <= '0;
          state  <= PH_FETCH;
        end
      endcase
    end
  end

  assign pmem_addr = pc_q;
  assign phase     = state;
  assign ir        = ir_q;
  assign mar       = mar_q;
  assign opcode    = opc_q;
  assign opnd1     = opa_q;
  assign opnd2     = opb_q;
  assign status    = sr_q;
  assign wb_en     = ctrl_q.wb;
  assign flag_en   = ctrl_q.flag;
  assign push_en   = ctrl_q.push;
  assign pop_en    = ctrl_q.pop;
  assign push_data = pc_q;

  assert_phase_step_R10: assert property (@(posedge clk) disable iff (rst)
    (state == PH_FETCH) |=> (state == PH_DECODE));
  assert_exec_returns_R10: assert property (@(posedge clk) disable iff (rst)
    (state == PH_EXEC) |=> (state == PH_FETCH));
  assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (state == PH_FETCH) |=> (pc_q == $past(pc_q) + PC_ONE && mar_q == $past(pc_q)));
  assert_strobe_window_R4: assert property (@(posedge clk) disable iff (rst)
    (state != PH_EXEC) |-> !(wb_en || flag_en || push_en || pop_en));
  assert_stack_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_en, pop_en}));
  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    (state == PH_EXEC && ctrl_q.legal && redirect && !from_stack)
      |=> (pc_q == $past(opa_q[PC_W-1:0])));
  assert_illegal_wipe_R9: assert property (@(posedge clk) disable iff (rst)
    (state == PH_EXEC && !ctrl_q.legal) |=> (pc_q == '0 && sr_q == '0 && ir_q == '0));
  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state != PH_EXEC) |=> $stable(sr_q));
endmodule

// File: tb/instruction_sequencer_test.sv
module instruction_sequencer_test;
  localparam int PC_W = 8;
  localparam int DEPTH = 1 << PC_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pmem_addr;
  logic [63:0]     pmem_rdata;
  logic [3:0]      alu_flags = 4'h0;
  logic [PC_W-1:0] pop_data = '0;
  logic [1:0]      phase;
  logic [63:0]     ir;
  logic [PC_W-1:0] mar;
  logic [15:0]     opcode;
  logic [15:0]     opnd1;
  logic [31:0]     opnd2;
  logic [3:0]      status;
  logic            wb_en, flag_en, push_en, pop_en;
  logic [PC_W-1:0] push_data;

  logic [63:0]     prog [DEPTH];
  int              n_cmp = 0;
  int              n_bad = 0;
  logic [PC_W-1:0] pc0;

  always #5 clk = ~clk;
  assign pmem_rdata = prog[pmem_addr];

  instruction_sequencer #(.PC_W(PC_W)) uut (
    .clk(clk), .rst(rst), .pmem_addr(pmem_addr), .pmem_rdata(pmem_rdata),
    .alu_flags(alu_flags), .pop_data(pop_data), .phase(phase), .ir(ir),
    .mar(mar), .opcode(opcode), .opnd1(opnd1), .opnd2(opnd2), .status(status),
    .wb_en(wb_en), .flag_en(flag_en), .push_en(push_en), .pop_en(pop_en),
    .push_data(push_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] op, input logic [15:0] a, input logic [31:0] b);
    prog[pmem_addr] = {op, a, b};
    pc0 = pmem_addr;
    chk("R10 fetch phase", phase, 0);
    @(negedge clk);
    chk("R2 ir", ir, {op, a, b});
    chk("R2 mar", mar, pc0);
    chk("R2 pc inc", pmem_addr, PC_W'(pc0 + 1));
    chk("R10 decode phase", phase, 1);
    @(negedge clk);
    chk("R3 fields", {opcode, opnd1, opnd2}, {op, a, b});
    chk("R10 exec phase", phase, 2);
  endtask

  task automatic strobes(input string req, input logic [3:0] exp);
    chk(req, {wb_en, flag_en, push_en, pop_en}, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) prog[i] = 64'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset pc", pmem_addr, 0);
    chk("R1 reset regs", {ir, mar, status}, 0);
    chk("R1 reset phase", phase, 0);
    strobes("R1 reset strobes", 4'b0000);

    // R4 strobe classes
    issue(16'h0000, 16'h1, 32'h2);     strobes("R4 nop", 4'b0000); @(negedge clk);
    issue(16'h0001, 16'h3, 32'hABCD);  strobes("R4 ldi", 4'b1000); @(negedge clk);
    issue(16'h0002, 16'h4, 32'h5);     strobes("R4 mov", 4'b1000); @(negedge clk);
    for (int op = 3; op <= 6; op++) begin
      alu_flags = 4'(op);
      issue(16'(op), 16'h7, 32'hDEAD_BEEF);
      strobes("R4 alu", 4'b1100);
      @(negedge clk);
      chk("R6 flags loaded", status, 4'(op));
    end
    // R5 compares; R6 hold on non-flag op
    alu_flags = 4'h9;
    issue(16'h0007, 16'h1, 32'h2); strobes("R5 cp", 4'b0100); @(negedge clk);
    chk("R6 cp flags", status, 4'h9);
    alu_flags = 4'h6;
    issue(16'h0001, 16'h1, 32'h2); @(negedge clk);
    chk("R6 hold", status, 4'h9);

    // R7 branch sweep over S/Z
    for (int op = 16'h11; op <= 16'h16; op++) begin
      for (int f = 0; f < 4; f++) begin
        logic s, z, take;
        logic [PC_W-1:0] tgt, nxt;
        s = f[1]; z = f[0];
        alu_flags = {s, 1'b0, z, 1'b0};
        issue(16'h0008, 16'h0, 32'h0);
        strobes("R5 cpi", 4'b0100);
        @(negedge clk);
        tgt = PC_W'(8'h80 + (op - 16'h11) * 8 + f * 2);
        case (op)
          16'h11: take = z;
          16'h12: take = !z;
          16'h13: take = !s;
          16'h14: take = !s && !z;
          16'h15: take = s || z;
          default: take = s;
        endcase
        issue(16'(op), 16'(tgt), 32'h0);
        strobes("R4 branch no strobe", 4'b0000);
        nxt = take ? tgt : PC_W'(pc0 + 1);
        @(negedge clk);
        chk("R7 branch pc", pmem_addr, nxt);
      end
    end
    issue(16'h0010, 16'h0033, 32'h0); @(negedge clk);
    chk("R7 jmp", pmem_addr, 8'h33);

    // R8 call / return
    issue(16'h0017, 16'h0020, 32'h0);
    strobes("R8 call push", 4'b0010);
    chk("R8 push data", push_data, PC_W'(pc0 + 1));
    @(negedge clk);
    chk("R8 call target", pmem_addr, 8'h20);
    pop_data = 8'h37;
    issue(16'h0018, 16'h0, 32'h0);
    strobes("R8 ret pop", 4'b0001);
    @(negedge clk);
    chk("R8 ret pc", pmem_addr, 8'h37);

    // R9 undefined opcode wipes state
    alu_flags = 4'hF;
    issue(16'h0008, 16'h0, 32'h0); @(negedge clk);
    chk("R6 set before wipe", status, 4'hF);
    issue(16'h00FF, 16'h1234, 32'h5678); @(negedge clk);
    chk("R9 pc", pmem_addr, 0);
    chk("R9 regs", {ir, mar, status}, 0);
    chk("R9 fields", {opcode, opnd1, opnd2}, 0);
    chk("R9 phase", phase, 0);
    issue(16'h0001, 16'h2, 32'h3); @(negedge clk);
    chk("R9 resumes at zero", mar, 0);

    // R1 reset mid-run
    issue(16'h0001, 16'h2, 32'h3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset", {pmem_addr, phase, wb_en}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule